// File: doc/BRIEF.md
# External Bus Byte-Lane Write Strobe Generator

This block runs the two-state (T1, T2) write and read cycles of a 32-bit external memory bus and produces the per-lane control outputs for those cycles. A request gives a write flag, a 2-bit target area and a 4-bit lane mask. Lane i carries data bits 8i+7..8i. The block accepts the request while idle and steps through T1 and then T2. It drives an active-low write strobe for each addressed lane. It drives active-low byte enables for the two lowest lanes. It flags the end of each cycle with a one-cycle done pulse.

Each rising edge of `clk` stands for one falling edge of the bus clock. The cycle that accepts a request sets the byte enables. The following edge, which falls inside T1, pulls the write strobes low. The edge after that, which falls inside T2, releases the strobes and the enables and ends the cycle.

Seven shared pins each pick port or control function on their own bit. In port mode a pin is a plain general-purpose I/O, and its direction comes from its own direction bit. In control mode a pin carries a strobe or an enable. A pin with no control signal floats in control mode, and so do all control pins while the bus is released.

Top module: `xbus_lane_strobe`

## Requirements
- R1: After a synchronous reset, no cycle is running. All write strobes and byte enables read high and `cyc_done` is low.
- R2: When a request is accepted, the byte enable of each addressed lane (lanes 0 and 1 only) is low for exactly two cycles, covering T1 and T2. This holds for reads and for writes.
- R3: In a write cycle the strobe of each addressed lane is low for exactly one cycle. It falls on the edge inside T1 and rises on the edge inside T2, so it is the second of the cycle's two cycles. Strobes of lanes that are not addressed stay high.
- R4: A read cycle (`req_write`=0) never drives any write strobe low.
- R5: Area codes 0 (SRAM), 1 (external ROM) and 2 (peripheral I/O) allow write strobes. A write to area code 3 runs the full cycle with byte enables but no strobes.
- R6: `cyc_done` is high for exactly one cycle, right after the edge that ends T2.
- R7: A request seen while a cycle is in T1 or T2 is ignored. If `req` is held high, a new cycle starts on the first edge after the previous one has ended, which gives one cycle every three clocks.
- R8: A pin whose `mode_ctl` bit is 0 is in port mode. `pin_oe` follows `port_dir` (1 = output) and `pin_o` follows `port_out`, bit by bit.
- R9: In control mode, pins 0–3 carry the write strobes of lanes 0–3 and pins 4–5 carry the byte enables of lanes 0–1, all driven (`pin_oe`=1). Pin 6 has no control signal and is floated (`pin_oe`=0).
- R10: While `bus_release` is high, every pin in control mode is floated. Pins in port mode are not affected.
- R11: `port_rd` always shows the level on `pin_i`, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one bus-clock falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus cycle request, sampled while idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_area | input | 2 | Target area: 0 SRAM, 1 ext ROM, 2 peripheral I/O, 3 other |
| req_lanes | input | 4 | Byte lanes taking part; bit i = data bits 8i+7..8i |
| bus_release | input | 1 | Floats all control-mode pins while high |
| mode_ctl | input | 7 | Per-pin select: 1 = control, 0 = port |
| port_dir | input | 7 | Per-pin port direction: 1 = output |
| port_out | input | 7 | Per-pin port output value |
| pin_i | input | 7 | Pin levels read back |
| cyc_done | output | 1 | One-cycle pulse at the end of each bus cycle |
| pin_o | output | 7 | Pin output values |
| pin_oe | output | 7 | Pin output enables (0 = high impedance) |
| port_rd | output | 7 | Port input readback |

## Verification
A pin's mode bit can change in the very cycle its lane strobe falls. The bus release can also rise while a strobe is low. The bench flips pin 1 to port mode and back, and raises `bus_release`, during live write cycles. It then compares every pin's enable and value against a reference model that tracks cycle age and lane mask on every clock. A correct design must switch that one pin at once, float only the control-mode pins, and leave the bus cycle's timing and done pulse unchanged.

// File: rtl/xbs_pkg.sv
// Package: shared types for the external bus lane strobe block.
// Assumes: bus cycles have exactly two states and no wait states.
package xbs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_T1   = 2'd1,
        PH_T2   = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        AR_SRAM  = 2'd0,
        AR_ROM   = 2'd1,
        AR_PERIO = 2'd2,
        AR_OTHER = 2'd3
    } area_e;

    // True when the target area takes lane write strobes.
    function automatic logic area_strobed(area_e a);
        return a != AR_OTHER;
    endfunction
endpackage

// File: rtl/xbs_bus_seq.sv
// Module: xbs_bus_seq
// Steps a bus cycle IDLE -> T1 -> T2 -> IDLE and latches the request
// fields for the whole cycle. Each clk rising edge is one bus-clock
// falling edge. Assumes req fields are valid whenever req is high.
module xbs_bus_seq
    import xbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [1:0]       req_area,
    input  logic [LANES-1:0] req_lanes,
    output phase_e           phase,
    output logic             accept,
    output logic             cyc_write,
    output area_e            cyc_area,
    output logic [LANES-1:0] cyc_lanes,
    output logic             done
);

    // Accept a new request only while no cycle is running.
    always_comb accept = (phase == PH_IDLE) && req;

    // Phase register: one clock each in T1 and T2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (accept) phase <= PH_T1;
                PH_T1:   phase <= PH_T2;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Capture the request fields on acceptance and hold them to the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_write <= 1'b0;
            cyc_area  <= AR_SRAM;
            cyc_lanes <= '0;
        end else if (accept) begin
            cyc_write <= req_write;
            cyc_area  <= area_e'(req_area);
            cyc_lanes <= req_lanes;
        end
    end

    // One-cycle completion pulse after the edge that ends T2.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (phase == PH_T2);
    end

    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |=> (phase == PH_T2)); // R3
    AST_DONE_AFTER_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2) |=> done); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_BUSY_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |=> $stable(cyc_lanes) && $stable(cyc_write)); // R7

endmodule

// File: rtl/xbs_lane_drv.sv
// Module: xbs_lane_drv
// Produces the active-low write strobe of every lane and the
// active-low byte enables of the lowest NBE lanes.
// Assumes the phase and latched fields come from xbs_bus_seq.
module xbs_lane_drv
    import xbs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NBE   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic             accept,
    input  logic [LANES-1:0] req_lanes,
    input  logic             cyc_write,
    input  area_e            cyc_area,
    input  logic [LANES-1:0] cyc_lanes,
    output logic [LANES-1:0] wr_n,
    output logic [NBE-1:0]   be_n
);

    logic wr_ok;

    // A strobe is allowed only for a write into a strobed area.
    always_comb wr_ok = cyc_write && area_strobed(cyc_area);

    for (genvar i = 0; i < LANES; i++) begin : g_wr
        // Strobe falls on the edge inside T1, rises on the edge inside T2.
        always_ff @(posedge clk) begin
            if (!rst_n)               wr_n[i] <= 1'b1;
            else if (phase == PH_T1)  wr_n[i] <= ~(wr_ok && cyc_lanes[i]);
            else                      wr_n[i] <= 1'b1;
        end

        AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_n[i] |=> wr_n[i]); // R3
    end

    for (genvar i = 0; i < NBE; i++) begin : g_be
        // Enable spans T1 and T2 for every addressed lane.
        always_ff @(posedge clk) begin
            if (!rst_n)               be_n[i] <= 1'b1;
            else if (accept)          be_n[i] <= ~req_lanes[i];
            else if (phase == PH_T2)  be_n[i] <= 1'b1;
        end

        AST_BE_COVERS_WR: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_n[i] |-> !be_n[i]); // R2
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (&wr_n) && (&be_n)); // R1
    AST_READ_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 && !cyc_write) |-> (&wr_n)); // R4
    AST_AREA_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 && cyc_area == AR_OTHER) |-> (&wr_n)); // R5

endmodule

// File: rtl/xbs_pin_mux.sv
// Module: xbs_pin_mux
// Per-pin choice between port function and control output.
// Pins 0..LANES-1 carry strobes, the next NBE pins carry byte enables,
// and any remaining pin floats in control mode.
module xbs_pin_mux #(
    parameter int LANES = 4,
    parameter int NBE   = 2,
    parameter int NPIN  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  mode_ctl,
    input  logic [NPIN-1:0]  port_dir,
    input  logic [NPIN-1:0]  port_out,
    input  logic [NPIN-1:0]  pin_i,
    input  logic             bus_release,
    input  logic [LANES-1:0] wr_n,
    input  logic [NBE-1:0]   be_n,
    output logic [NPIN-1:0]  pin_o,
    output logic [NPIN-1:0]  pin_oe,
    output logic [NPIN-1:0]  port_rd
);

    localparam int NCTL = LANES + NBE;

    logic [NPIN-1:0] ctl_val;
    logic [NPIN-1:0] ctl_drv;

    for (genvar j = 0; j < NPIN; j++) begin : g_pin
        if (j < LANES) begin : g_strobe
            assign ctl_val[j] = wr_n[j];
            assign ctl_drv[j] = 1'b1;
        end else if (j < NCTL) begin : g_enable
            assign ctl_val[j] = be_n[j-LANES];
            assign ctl_drv[j] = 1'b1;
        end else begin : g_spare
            assign ctl_val[j] = 1'b1;
            assign ctl_drv[j] = 1'b0;
        end

        // Select port or control driver for this pin.
        always_comb begin
            if (mode_ctl[j]) begin
                pin_o[j]  = ctl_val[j];
                pin_oe[j] = ctl_drv[j] && !bus_release;
            end else begin
                pin_o[j]  = port_out[j];
                pin_oe[j] = port_dir[j];
            end
        end
    end

    // Port readback always reflects the pin level.
    always_comb port_rd = pin_i;

    AST_RELEASE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_release |-> ((pin_oe & mode_ctl) == '0)); // R10

endmodule

// File: rtl/xbus_lane_strobe.sv
// Module: xbus_lane_strobe (top)
// Two-state external bus cycle engine with per-lane write strobes,
// low-lane byte enables and a per-pin port/control multiplexer.
// Assumes one clk rising edge per bus-clock falling edge and no waits.
module xbus_lane_strobe
    import xbs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NBE   = 2,
    parameter int NPIN  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic [1:0]       req_area,
    input  logic [LANES-1:0] req_lanes,
    input  logic             bus_release,
    input  logic [NPIN-1:0]  mode_ctl,
    input  logic [NPIN-1:0]  port_dir,
    input  logic [NPIN-1:0]  port_out,
    input  logic [NPIN-1:0]  pin_i,
    output logic             cyc_done,
    output logic [NPIN-1:0]  pin_o,
    output logic [NPIN-1:0]  pin_oe,
    output logic [NPIN-1:0]  port_rd
);

    phase_e           phase;
    logic             accept;
    logic             cyc_write;
    area_e            cyc_area;
    logic [LANES-1:0] cyc_lanes;
    logic [LANES-1:0] wr_n;
    logic [NBE-1:0]   be_n;

    xbs_bus_seq #(.LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_area(req_area), .req_lanes(req_lanes), .phase(phase),
        .accept(accept), .cyc_write(cyc_write), .cyc_area(cyc_area),
        .cyc_lanes(cyc_lanes), .done(cyc_done)
    );

    xbs_lane_drv #(.LANES(LANES), .NBE(NBE)) u_lane (
        .clk(clk), .rst_n(rst_n), .phase(phase), .accept(accept),
        .req_lanes(req_lanes), .cyc_write(cyc_write), .cyc_area(cyc_area),
        .cyc_lanes(cyc_lanes), .wr_n(wr_n), .be_n(be_n)
    );

    xbs_pin_mux #(.LANES(LANES), .NBE(NBE), .NPIN(NPIN)) u_mux (
        .clk(clk), .rst_n(rst_n), .mode_ctl(mode_ctl), .port_dir(port_dir),
        .port_out(port_out), .pin_i(pin_i), .bus_release(bus_release),
        .wr_n(wr_n), .be_n(be_n), .pin_o(pin_o), .pin_oe(pin_oe),
        .port_rd(port_rd)
    );

endmodule

// File: tb/test_xbus_lane_strobe.sv
module test_xbus_lane_strobe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0, req_write = 1'b0, bus_release = 1'b0;
    logic [1:0] req_area = 2'd0;
    logic [3:0] req_lanes = 4'd0;
    logic [6:0] mode_ctl = 7'h3F, port_dir = 7'h00, port_out = 7'h00, pin_i = 7'h00;
    logic       cyc_done;
    logic [6:0] pin_o, pin_oe, port_rd;

    int errors = 0, checks = 0;
    bit chk_on = 1'b0;

    // reference model state
    int       age = 0;
    bit       m_wr = 0, m_done = 0;
    int       m_area = 0;
    bit [3:0] m_lanes = 0;

    always #4 clk = ~clk;

    xbus_lane_strobe i_xbus_lane_strobe (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_area(req_area), .req_lanes(req_lanes), .bus_release(bus_release),
        .mode_ctl(mode_ctl), .port_dir(port_dir), .port_out(port_out),
        .pin_i(pin_i), .cyc_done(cyc_done), .pin_o(pin_o), .pin_oe(pin_oe),
        .port_rd(port_rd)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Behavioural model: cycle age since acceptance.
    always @(posedge clk) begin
        if (!rst_n) begin
            age = 0; m_done = 0;
        end else begin
            m_done = (age == 2);
            if (age == 0) begin
                if (req) begin
                    age = 1; m_wr = req_write; m_area = req_area; m_lanes = req_lanes;
                end
            end else if (age == 1) age = 2;
            else age = 0;
        end
    end

    function automatic bit exp_wr_n(int lane);
        return !(age == 2 && m_wr && m_area != 3 && m_lanes[lane]);
    endfunction
    function automatic bit exp_be_n(int lane);
        return !((age == 1 || age == 2) && m_lanes[lane]);
    endfunction

    // Compare every clock, mid-cycle.
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R6 cyc_done", {7'd0, cyc_done}, {7'd0, m_done});
            chk("R11 port_rd", {1'b0, port_rd}, {1'b0, pin_i});
            for (int j = 0; j < 7; j++) begin
                bit eoe, eo;
                string tg;
                if (!mode_ctl[j]) begin
                    eoe = port_dir[j]; eo = port_out[j]; tg = "R8 port pin";
                end else if (j == 6) begin
                    eoe = 0; eo = 1; tg = "R9 spare pin";
                end else begin
                    eoe = !bus_release;
                    eo  = (j < 4) ? exp_wr_n(j) : exp_be_n(j - 4);
                    tg  = bus_release ? "R10 released pin" :
                          (j < 4) ? "R3 strobe pin" : "R2 enable pin";
                end
                chk({tg, " oe"}, {7'd0, pin_oe[j]}, {7'd0, eoe});
                if (eoe) chk({tg, " value"}, {7'd0, pin_o[j]}, {7'd0, eo});
            end
        end
    end

    // Issue one request; count strobe-low samples on pins 0..3 over the cycle.
    task automatic run_cyc(bit w, logic [1:0] ar, logic [3:0] ln, output int lows, output int dones);
        lows = 0; dones = 0;
        req = 1; req_write = w; req_area = ar; req_lanes = ln;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            for (int j = 0; j < 4; j++) if (pin_oe[j] && !pin_o[j]) lows++;
            if (cyc_done) dones++;
            #1 req = 0;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got hang expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lows, dones;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        chk_on = 1;
        @(negedge clk);
        // R1: quiet after reset
        chk("R1 strobe/enable pins high", {2'b0, pin_o[5:0]}, 8'h3F);
        chk("R1 done low", {7'd0, cyc_done}, 8'd0);
        #1;
        // R3 / R5 areas 0..2 strobe, area 3 does not
        run_cyc(1, 2'd0, 4'hF, lows, dones);
        chk("R3 SRAM all-lane strobe samples", lows[7:0], 8'd4);
        chk("R6 one done per cycle", dones[7:0], 8'd1);
        run_cyc(1, 2'd1, 4'b0101, lows, dones);
        chk("R3 ROM partial strobe samples", lows[7:0], 8'd2);
        run_cyc(1, 2'd2, 4'b1000, lows, dones);
        chk("R5 peripheral strobe samples", lows[7:0], 8'd1);
        run_cyc(1, 2'd3, 4'hF, lows, dones);
        chk("R5 other area no strobe", lows[7:0], 8'd0);
        // R4 read: enables but no strobes
        run_cyc(0, 2'd0, 4'b0011, lows, dones);
        chk("R4 read no strobe", lows[7:0], 8'd0);
        // R7 held request: one cycle per three clocks
        req = 1; req_write = 1; req_area = 0; req_lanes = 4'b0010;
        dones = 0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (cyc_done) dones++;
        end
        #1 req = 0;
        chk("R7 held request done count", dones[7:0], 8'd3);
        repeat (3) @(negedge clk);
        // R8 / R11 port mode patterns
        #1 mode_ctl = 7'h00; port_dir = 7'h55; port_out = 7'h33; pin_i = 7'h4A;
        @(negedge clk);
        #1 port_dir = 7'h2A; port_out = 7'h7C; pin_i = 7'h15;
        @(negedge clk);
        // Mixed mode: pin 1 flips mode while its strobe is low; release in T2
        #1 mode_ctl = 7'h7D; port_dir = 7'h7F; port_out = 7'h00;
        req = 1; req_write = 1; req_area = 0; req_lanes = 4'hF;
        @(negedge clk);
        #1 req = 0;
        @(negedge clk);
        chk("R8 pin1 port while strobe low", {7'd0, pin_o[1]}, 8'd0);
        chk("R3 pin0 strobe low in T2", {7'd0, pin_o[0]}, 8'd0);
        #1 mode_ctl = 7'h7F; bus_release = 1;
        repeat (2) @(negedge clk);
        chk("R10 control pins float", {1'b0, pin_oe}, 8'd0);
        #1 bus_release = 0;
        // R9 control mapping with release off, write on lanes 0 and 2
        run_cyc(1, 2'd1, 4'b0101, lows, dones);
        chk("R9 mapped strobe samples", lows[7:0], 8'd2);
        chk("R9 spare pin floats", {7'd0, pin_oe[6]}, 8'd0);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule